// File: doc/BRIEF.md
# Wired Interrupt Source Pending Gateway

This block is the per-source front end of an interrupt controller for wired sources. For each of a parameterised number of sources it keeps a source mode, a pending bit and an enable bit. Each raw wire passes through a synchronizer. A rectified input is then formed according to the source mode. The block decides from that input, and from the domain's delivery style, when the pending bit is set and when it is cleared. In direct delivery a hart claims interrupts. In message delivery a forwarding engine sends them as messages.

Software reaches the block through a plain write port. One write selects a source by number and loads its mode. Pending and enable can each be set or cleared by a bit mask or by a source number. A claim strobe and a forward strobe each carry a source number. The per-source request output is pending AND enable AND the domain-wide enable. Arbitration, delegation and the bus fabric sit outside the block.

Top module: `gw_pend_gateway`

## Requirements
- R1: After reset every source is Inactive, with pending, enable and request all zero.
- R2: The mode field is coded 0 Inactive, 1 Detached, 4 rising edge, 5 falling edge, 6 active-high level and 7 active-low level. Every other code is treated as Inactive. An Inactive source reads pending and enable as zero and ignores all writes to them. Writing Inactive to a source clears both bits.
- R3: Each wire passes through a two-stage synchronizer. The rectified input is the synchronized wire in modes 4 and 6, its inverse in modes 5 and 7, and zero in Detached and Inactive. A wire change reaches pending on the third clock edge.
- R4: In level modes with direct delivery (deliver_msg=0), pending equals the rectified input. Set and clear writes, claims and forwards have no effect.
- R5: In level modes with message delivery (deliver_msg=1), pending is set by a low-to-high change of the rectified input, or by a set write while that input is high. It is cleared by a forward, by a clear write, or whenever the rectified input is low.
- R6: In edge modes, pending is set by the selected wire transition or by a set write. It is cleared by a claim, a forward or a clear write.
- R7: In Detached mode the wire is ignored. Pending changes only through set and clear writes, and claims and forwards have no effect.
- R8: A mode write sets pending when the rectified input under the new mode is high. It otherwise keeps pending, except where R2 or a level rule forces pending low. Swapping between modes 6 and 7 inverts the rectified input.
- R9: When a set event and a clear event reach the same source in the same cycle, the set wins.
- R10: Enable is set or cleared by a bit mask or by a source number, and a set wins over a clear. A source number of 0 or above NUM_SRC has no effect on any number-addressed port.
- R11: req_o equals pending AND enable AND dom_enable. dom_enable never alters pending or enable.
- R12: Source n corresponds to bit n-1 of every mask. A by-mask write and a by-number write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_wire | input | NUM_SRC | Raw source wires, asynchronous |
| deliver_msg | input | 1 | 1 selects message delivery, 0 selects direct delivery |
| dom_enable | input | 1 | Domain-wide delivery enable |
| cfg_we | input | 1 | Mode write strobe |
| cfg_num | input | NUM_W | Source number for the mode write |
| cfg_mode | input | 3 | Mode code to write |
| setip_we | input | 1 | Set-pending by mask strobe |
| setip_bits | input | NUM_SRC | Set-pending mask |
| clrip_we | input | 1 | Clear-pending by mask strobe |
| clrip_bits | input | NUM_SRC | Clear-pending mask |
| setipnum_we | input | 1 | Set-pending by number strobe |
| setipnum | input | NUM_W | Source number to set pending |
| clripnum_we | input | 1 | Clear-pending by number strobe |
| clripnum | input | NUM_W | Source number to clear pending |
| setie_we | input | 1 | Set-enable by mask strobe |
| setie_bits | input | NUM_SRC | Set-enable mask |
| clrie_we | input | 1 | Clear-enable by mask strobe |
| clrie_bits | input | NUM_SRC | Clear-enable mask |
| setienum_we | input | 1 | Set-enable by number strobe |
| setienum | input | NUM_W | Source number to enable |
| clrienum_we | input | 1 | Clear-enable by number strobe |
| clrienum | input | NUM_W | Source number to disable |
| claim_we | input | 1 | Claim strobe |
| claim_num | input | NUM_W | Claimed source number |
| fwd_we | input | 1 | Message-forwarded strobe |
| fwd_num | input | NUM_W | Forwarded source number |
| pend_o | output | NUM_SRC | Pending bits |
| en_o | output | NUM_SRC | Enable bits |
| req_o | output | NUM_SRC | Pending AND enable AND dom_enable |

## Verification
The sharpest overlap is a detected edge arriving in the same cycle as a forward, claim or clear for that same source. The bench provokes it by raising the wire and then issuing all three clears exactly on the third clock edge, the one where the synchronized edge lands. It judges the result by pending staying set. A second overlap puts by-mask and by-number pending writes on one source in the same cycle, where the set must win. A mode write that makes the rectified input high is also checked to set pending in that cycle. A behavioural model tracks every source on every clock as well.

// File: rtl/gw_pkg.sv
package gw_pkg;

    typedef enum logic [2:0] {
        SM_OFF    = 3'd0,
        SM_DETACH = 3'd1,
        SM_RISE   = 3'd4,
        SM_FALL   = 3'd5,
        SM_HIGH   = 3'd6,
        SM_LOW    = 3'd7
    } src_mode_e;

    typedef struct packed {
        src_mode_e mode;
        logic      pend;
        logic      en;
    } slot_st_t;

    // Unused codes collapse to Inactive.
    function automatic src_mode_e legal_mode(logic [2:0] raw);
        case (raw)
            3'd1:    return SM_DETACH;
            3'd4:    return SM_RISE;
            3'd5:    return SM_FALL;
            3'd6:    return SM_HIGH;
            3'd7:    return SM_LOW;
            default: return SM_OFF;
        endcase
    endfunction

    function automatic logic rectify(src_mode_e m, logic w);
        case (m)
            SM_RISE, SM_HIGH: return w;
            SM_FALL, SM_LOW:  return ~w;
            default:          return 1'b0;
        endcase
    endfunction

    function automatic logic is_level(src_mode_e m);
        return (m == SM_HIGH) || (m == SM_LOW);
    endfunction

    function automatic logic is_edge(src_mode_e m);
        return (m == SM_RISE) || (m == SM_FALL);
    endfunction

endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] wire_s,
    output logic [W-1:0] wire_prev
);
    // Stages 0..STAGES-1 synchronize; the extra last stage holds the prior sample.
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] stg_d [DEPTH];
    logic [W-1:0] stg_q [DEPTH];

    always_comb begin
        stg_d[0] = raw;
        for (int k = 1; k < DEPTH; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stg_q[k] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign wire_s    = stg_q[STAGES-1];
    assign wire_prev = stg_q[STAGES];

endmodule

// File: rtl/gw_slot.sv
module gw_slot
    import gw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       deliver_msg,
    input  logic       wire_s,
    input  logic       wire_prev,
    input  logic       cfg_hit,
    input  logic [2:0] cfg_mode,
    input  logic       set_p,
    input  logic       clr_p,
    input  logic       set_e,
    input  logic       clr_e,
    input  logic       claim_hit,
    input  logic       fwd_hit,
    output logic       pend_o,
    output logic       en_o
);
    slot_st_t  cur_q, nxt_d;
    src_mode_e eff;
    logic      rect, rect_prev, edge_evt, cfg_set;

    always_comb begin
        nxt_d     = cur_q;
        eff       = cfg_hit ? legal_mode(cfg_mode) : cur_q.mode;
        nxt_d.mode = eff;
        rect      = rectify(eff, wire_s);
        rect_prev = rectify(eff, wire_prev);
        edge_evt  = ((eff == SM_RISE) &&  wire_s && !wire_prev) ||
                    ((eff == SM_FALL) && !wire_s &&  wire_prev);
        cfg_set   = cfg_hit && rect;

        case (eff)
            SM_DETACH: nxt_d.pend = set_p | (cur_q.pend & ~clr_p);
            SM_RISE, SM_FALL:
                nxt_d.pend = edge_evt | set_p | cfg_set |
                             (cur_q.pend & ~(clr_p | claim_hit | fwd_hit));
            SM_HIGH, SM_LOW: begin
                if (!deliver_msg) begin
                    nxt_d.pend = rect;
                end else begin
                    nxt_d.pend = rect & (~rect_prev | set_p | cfg_set |
                                         (cur_q.pend & ~(clr_p | fwd_hit)));
                end
            end
            default: nxt_d.pend = 1'b0;
        endcase

        nxt_d.en = (eff == SM_OFF) ? 1'b0 : (set_e | (cur_q.en & ~clr_e));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{mode: SM_OFF, pend: 1'b0, en: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pend_o = cur_q.pend;
    assign en_o   = cur_q.en;

    p_off_ignores_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == SM_OFF && !cfg_hit && set_p) |=> !cur_q.pend);

    p_direct_level_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_level(cur_q.mode) && !deliver_msg && !cfg_hit && rect && (claim_hit || clr_p))
        |=> cur_q.pend);

    p_msg_low_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_level(cur_q.mode) && deliver_msg && !cfg_hit && !rect) |=> !cur_q.pend);

    p_edge_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge(cur_q.mode) && !cfg_hit && !edge_evt && !set_p && clr_p) |=> !cur_q.pend);

    p_detached_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == SM_DETACH && !cfg_hit && !set_p && !clr_p)
        |=> cur_q.pend == $past(cur_q.pend));

    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge(cur_q.mode) && !cfg_hit && edge_evt && (clr_p || claim_hit || fwd_hit))
        |=> cur_q.pend);

endmodule

// File: rtl/gw_pend_gateway.sv
module gw_pend_gateway
    import gw_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_W      = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_wire,
    input  logic               deliver_msg,
    input  logic               dom_enable,
    input  logic               cfg_we,
    input  logic [NUM_W-1:0]   cfg_num,
    input  logic [2:0]         cfg_mode,
    input  logic               setip_we,
    input  logic [NUM_SRC-1:0] setip_bits,
    input  logic               clrip_we,
    input  logic [NUM_SRC-1:0] clrip_bits,
    input  logic               setipnum_we,
    input  logic [NUM_W-1:0]   setipnum,
    input  logic               clripnum_we,
    input  logic [NUM_W-1:0]   clripnum,
    input  logic               setie_we,
    input  logic [NUM_SRC-1:0] setie_bits,
    input  logic               clrie_we,
    input  logic [NUM_SRC-1:0] clrie_bits,
    input  logic               setienum_we,
    input  logic [NUM_W-1:0]   setienum,
    input  logic               clrienum_we,
    input  logic [NUM_W-1:0]   clrienum,
    input  logic               claim_we,
    input  logic [NUM_W-1:0]   claim_num,
    input  logic               fwd_we,
    input  logic [NUM_W-1:0]   fwd_num,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] req_o
);
    // Source number n selects bit n-1; number 0 and out-of-range numbers select nothing.
    function automatic logic [NUM_SRC-1:0] num_hit(logic we, logic [NUM_W-1:0] num);
        logic [NUM_SRC-1:0] h;
        for (int k = 0; k < NUM_SRC; k++) begin
            h[k] = we && (num == NUM_W'(k + 1));
        end
        return h;
    endfunction

    logic [NUM_SRC-1:0] wire_s, wire_prev;
    logic [NUM_SRC-1:0] cfg_hit, set_p, clr_p, set_e, clr_e, claim_hit, fwd_hit;

    gw_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (src_wire),
        .wire_s    (wire_s),
        .wire_prev (wire_prev)
    );

    always_comb begin
        cfg_hit   = num_hit(cfg_we, cfg_num);
        set_p     = ({NUM_SRC{setip_we}} & setip_bits) | num_hit(setipnum_we, setipnum);
        clr_p     = ({NUM_SRC{clrip_we}} & clrip_bits) | num_hit(clripnum_we, clripnum);
        set_e     = ({NUM_SRC{setie_we}} & setie_bits) | num_hit(setienum_we, setienum);
        clr_e     = ({NUM_SRC{clrie_we}} & clrie_bits) | num_hit(clrienum_we, clrienum);
        claim_hit = num_hit(claim_we, claim_num);
        fwd_hit   = num_hit(fwd_we, fwd_num);
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        gw_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .deliver_msg (deliver_msg),
            .wire_s      (wire_s[g]),
            .wire_prev   (wire_prev[g]),
            .cfg_hit     (cfg_hit[g]),
            .cfg_mode    (cfg_mode),
            .set_p       (set_p[g]),
            .clr_p       (clr_p[g]),
            .set_e       (set_e[g]),
            .clr_e       (clr_e[g]),
            .claim_hit   (claim_hit[g]),
            .fwd_hit     (fwd_hit[g]),
            .pend_o      (pend_o[g]),
            .en_o        (en_o[g])
        );
    end

    assign req_o = pend_o & en_o & {NUM_SRC{dom_enable}};

endmodule

// File: tb/gw_pend_gateway_test.sv
`timescale 1ns/1ps
module gw_pend_gateway_test;
    localparam int N  = 8;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_wire = '0;
    logic deliver_msg = 1'b0, dom_enable = 1'b1;
    logic cfg_we = 0; logic [NW-1:0] cfg_num = '0; logic [2:0] cfg_mode = '0;
    logic setip_we = 0, clrip_we = 0; logic [N-1:0] setip_bits = '0, clrip_bits = '0;
    logic setipnum_we = 0, clripnum_we = 0; logic [NW-1:0] setipnum = '0, clripnum = '0;
    logic setie_we = 0, clrie_we = 0; logic [N-1:0] setie_bits = '0, clrie_bits = '0;
    logic setienum_we = 0, clrienum_we = 0; logic [NW-1:0] setienum = '0, clrienum = '0;
    logic claim_we = 0, fwd_we = 0; logic [NW-1:0] claim_num = '0, fwd_num = '0;
    logic [N-1:0] pend_o, en_o, req_o;

    int nchk = 0, nfail = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    gw_pend_gateway #(.NUM_SRC(N), .SYNC_STAGES(2)) uut (.*);

    // ---------------- behavioural reference model ----------------
    logic [2:0]   mmode [N];
    logic [N-1:0] mp = '0, me = '0, ms1 = '0, ms2 = '0, mprev = '0;
    logic [2:0]   m;
    bit rect, rprev, cfgh, sp, cp, se, ce, clm, fw, evt;

    function automatic logic [2:0] legalize(logic [2:0] c);
        return (c == 1 || c >= 4) ? c : 3'd0;
    endfunction

    function automatic bit rectified(logic [2:0] md, bit w);
        if (md == 4 || md == 6) return w;
        if (md == 5 || md == 7) return !w;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mmode[i] = 3'd0;
            mp = '0; me = '0; ms1 = '0; ms2 = '0; mprev = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                cfgh = cfg_we && cfg_num == i + 1;
                m = cfgh ? legalize(cfg_mode) : mmode[i];
                mmode[i] = m;
                sp  = (setip_we && setip_bits[i]) || (setipnum_we && setipnum == i + 1);
                cp  = (clrip_we && clrip_bits[i]) || (clripnum_we && clripnum == i + 1);
                se  = (setie_we && setie_bits[i]) || (setienum_we && setienum == i + 1);
                ce  = (clrie_we && clrie_bits[i]) || (clrienum_we && clrienum == i + 1);
                clm = claim_we && claim_num == i + 1;
                fw  = fwd_we && fwd_num == i + 1;
                rect  = rectified(m, ms2[i]);
                rprev = rectified(m, mprev[i]);
                if (m == 0) begin
                    mp[i] = 0;
                end else if (m == 1) begin
                    if (sp) mp[i] = 1; else if (cp) mp[i] = 0;
                end else if (m == 4 || m == 5) begin
                    evt = (m == 4) ? (ms2[i] && !mprev[i]) : (!ms2[i] && mprev[i]);
                    if (evt || sp || (cfgh && rect)) mp[i] = 1;
                    else if (cp || clm || fw) mp[i] = 0;
                end else if (!deliver_msg) begin
                    mp[i] = rect;
                end else begin
                    if (!rect) mp[i] = 0;
                    else if (!rprev || sp || cfgh) mp[i] = 1;
                    else if (cp || fw) mp[i] = 0;
                end
                if (m == 0) me[i] = 0;
                else if (se) me[i] = 1;
                else if (ce) me[i] = 0;
            end
            mprev = ms2; ms2 = ms1; ms1 = src_wire;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", r, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        nchk++;
        if (pend_o !== mp || en_o !== me || req_o !== (mp & me & {N{dom_enable}})) begin
            nfail++;
            $display("FAIL %s model: pend %h/%h en %h/%h req %h/%h", cur_req,
                     pend_o, mp, en_o, me, req_o, mp & me & {N{dom_enable}});
        end
        cfg_we = 0; setip_we = 0; clrip_we = 0; setipnum_we = 0; clripnum_we = 0;
        setie_we = 0; clrie_we = 0; setienum_we = 0; clrienum_we = 0;
        claim_we = 0; fwd_we = 0;
    endtask

    task automatic settle(); repeat (4) cyc(); endtask

    task automatic wcfg(int n, int md);
        cfg_we = 1; cfg_num = NW'(n); cfg_mode = 3'(md); cyc();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R1: watchdog expired, got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        cur_req = "R1";
        chk("R1", 32'(pend_o), 0); chk("R1", 32'(en_o), 0); chk("R1", 32'(req_o), 0);

        // R2: inactive and illegal modes
        cur_req = "R2";
        setip_we = 1; setip_bits = '1; setie_we = 1; setie_bits = '1; cyc();
        chk("R2", 32'(pend_o), 0); chk("R2", 32'(en_o), 0);
        wcfg(1, 3);
        setip_we = 1; setip_bits = 8'h01; cyc();
        chk("R2", 32'(pend_o[0]), 0);

        // R7: detached
        cur_req = "R7";
        wcfg(2, 1);
        src_wire[1] = 1; settle();
        chk("R7", 32'(pend_o[1]), 0);
        setipnum_we = 1; setipnum = 2; cyc();
        chk("R7", 32'(pend_o[1]), 1);
        claim_we = 1; claim_num = 2; fwd_we = 1; fwd_num = 2; cyc();
        chk("R7", 32'(pend_o[1]), 1);
        src_wire[1] = 0; settle();
        chk("R7", 32'(pend_o[1]), 1);
        clripnum_we = 1; clripnum = 2; cyc();
        chk("R7", 32'(pend_o[1]), 0);

        // R4 / R3: level, direct delivery
        cur_req = "R4";
        deliver_msg = 0;
        wcfg(3, 6);
        chk("R4", 32'(pend_o[2]), 0);
        setip_we = 1; setip_bits = 8'h04; cyc();
        chk("R4", 32'(pend_o[2]), 0);
        src_wire[2] = 1; cyc(); cyc();
        chk("R3", 32'(pend_o[2]), 0);
        cyc();
        chk("R3", 32'(pend_o[2]), 1);
        claim_we = 1; claim_num = 3; clrip_we = 1; clrip_bits = 8'h04;
        clripnum_we = 1; clripnum = 3; cyc();
        chk("R4", 32'(pend_o[2]), 1);
        src_wire[2] = 0; repeat (3) cyc();
        chk("R4", 32'(pend_o[2]), 0);

        // R8: mode writes, inversion
        cur_req = "R8";
        wcfg(4, 1);
        wcfg(4, 7);
        chk("R8", 32'(pend_o[3]), 1);
        wcfg(4, 6);
        chk("R8", 32'(pend_o[3]), 0);

        // R5: level, message delivery
        cur_req = "R5";
        deliver_msg = 1;
        wcfg(5, 6);
        src_wire[4] = 1; repeat (3) cyc();
        chk("R5", 32'(pend_o[4]), 1);
        fwd_we = 1; fwd_num = 5; cyc();
        chk("R5", 32'(pend_o[4]), 0);
        cyc(); cyc();
        chk("R5", 32'(pend_o[4]), 0);
        setip_we = 1; setip_bits = 8'h10; cyc();
        chk("R5", 32'(pend_o[4]), 1);
        clrip_we = 1; clrip_bits = 8'h10; cyc();
        chk("R5", 32'(pend_o[4]), 0);
        setipnum_we = 1; setipnum = 5; cyc();
        chk("R5", 32'(pend_o[4]), 1);
        src_wire[4] = 0; settle();
        chk("R5", 32'(pend_o[4]), 0);
        setipnum_we = 1; setipnum = 5; cyc();
        chk("R5", 32'(pend_o[4]), 0);

        // R6: edge modes
        cur_req = "R6";
        wcfg(6, 4);
        src_wire[5] = 1; repeat (3) cyc();
        chk("R6", 32'(pend_o[5]), 1);
        claim_we = 1; claim_num = 6; cyc();
        chk("R6", 32'(pend_o[5]), 0);
        src_wire[5] = 0; settle();
        chk("R6", 32'(pend_o[5]), 0);
        setip_we = 1; setip_bits = 8'h20; cyc();
        chk("R6", 32'(pend_o[5]), 1);
        cur_req = "R8";
        wcfg(6, 4);
        chk("R8", 32'(pend_o[5]), 1);
        cur_req = "R6";
        clripnum_we = 1; clripnum = 6; cyc();
        chk("R6", 32'(pend_o[5]), 0);
        cur_req = "R8";
        wcfg(7, 5);
        chk("R8", 32'(pend_o[6]), 1);
        cur_req = "R6";
        clrip_we = 1; clrip_bits = 8'h40; cyc();
        chk("R6", 32'(pend_o[6]), 0);
        src_wire[6] = 1; settle();
        chk("R6", 32'(pend_o[6]), 0);
        src_wire[6] = 0; repeat (3) cyc();
        chk("R6", 32'(pend_o[6]), 1);
        fwd_we = 1; fwd_num = 7; cyc();
        chk("R6", 32'(pend_o[6]), 0);

        // R9: edge lands with clears in the same cycle
        cur_req = "R9";
        src_wire[5] = 1; cyc(); cyc();
        fwd_we = 1; fwd_num = 6; claim_we = 1; claim_num = 6;
        clrip_we = 1; clrip_bits = 8'h20; cyc();
        chk("R9", 32'(pend_o[5]), 1);

        // R10: enables
        cur_req = "R10";
        setie_we = 1; setie_bits = 8'h0F; cyc();
        chk("R10", 32'(en_o), 32'h0E);
        setienum_we = 1; setienum = 8; cyc();
        chk("R10", 32'(en_o), 32'h0E);
        setienum_we = 1; setienum = 0; cyc();
        setienum_we = 1; setienum = 9; cyc();
        chk("R10", 32'(en_o), 32'h0E);
        setienum_we = 1; setienum = 6; cyc();
        chk("R10", 32'(en_o), 32'h2E);
        clrienum_we = 1; clrienum = 3; setie_we = 1; setie_bits = 8'h04; cyc();
        chk("R10", 32'(en_o), 32'h2E);
        clrie_we = 1; clrie_bits = 8'h02; cyc();
        chk("R10", 32'(en_o), 32'h2C);

        // R11: domain enable gates delivery only
        cur_req = "R11";
        chk("R11", 32'(req_o[5]), 1);
        dom_enable = 0; cyc();
        chk("R11", 32'(req_o), 0);
        chk("R11", 32'(pend_o[5]), 1);
        chk("R11", 32'(en_o), 32'h2C);
        dom_enable = 1; cyc();
        chk("R11", 32'(req_o[5]), 1);

        // R12: mask and number in the same cycle
        cur_req = "R12";
        setip_we = 1; setip_bits = 8'h02; clripnum_we = 1; clripnum = 2; cyc();
        chk("R12", 32'(pend_o[1]), 1);
        clrip_we = 1; clrip_bits = 8'h02; clripnum_we = 1; clripnum = 2; cyc();
        chk("R12", 32'(pend_o[1]), 0);
        setip_we = 1; setip_bits = 8'h02; setipnum_we = 1; setipnum = 2; cyc();
        chk("R12", 32'(pend_o[1]), 1);

        // R2: making a source inactive clears it
        cur_req = "R2";
        wcfg(6, 0);
        chk("R2", 32'(pend_o[5]), 0); chk("R2", 32'(en_o[5]), 0);
        setipnum_we = 1; setipnum = 6; setienum_we = 1; setienum = 6; cyc();
        chk("R2", 32'(pend_o[5]), 0); chk("R2", 32'(en_o[5]), 0);

        cyc();
        done = 1;
        summary();
        $finish;
    end

endmodule